// File: doc/BRIEF.md
# PLL Speed Change Sequencer

This block is the control state machine that moves a chip's bus clock from one PLL-derived speed to another without letting the bus run on a PLL that has not settled. A request carries a 2-bit speed code and a settle time, given in reference-clock cycles. The block drives four controls in a fixed order. First it moves the bus clock select to the slow reference clock. Then it turns the PLL off, which also returns the loop filter to wide bandwidth. Then it writes the new speed code, and then it turns the PLL back on. The analog loop, the VCO and the glitch-free clock multiplexer are outside the block. They see only these control outputs.

While the PLL ramps, the filter stays wide. Once most of the settle time has passed, the filter is switched to narrow bandwidth. When the rest of the settle time has passed, the bus is returned to the fast PLL clock and a one-cycle done pulse is issued. The counter runs on the reference clock, which never stops. The narrow handover comes at N - floor(N/10) cycles and the bus switch at N cycles, both counted from the edge where the PLL is enabled.

A request is taken only when the block is idle. If the requested code is already running on the fast clock, the request completes at once without touching the PLL. A request that arrives while a change is in progress is dropped. So is a request with a zero settle time. Either one raises a one-cycle error flag.

Top module: `pll_speed_sequencer`

## Requirements
- R1: After reset, busSelFast, pllEnable and filterNarrow are 0, speedSel is 00, and busy, done and reqError are 0.
- R2: When a change starts from the fast clock, busSelFast falls at least one cycle before pllEnable falls.
- R3: filterNarrow is 0 whenever pllEnable is 0, so turning the PLL off always selects wide bandwidth.
- R4: speedSel changes only on an edge where pllEnable was 0 and busSelFast was 0. The new code appears after pllEnable has fallen and before pllEnable rises again.
- R5: For an accepted settle count N, filterNarrow rises exactly N - floor(N/10) cycles after pllEnable rises. speedSel then equals the requested code.
- R6: busSelFast rises exactly N cycles after pllEnable rises. busSelFast is never 1 unless pllEnable and filterNarrow are both 1.
- R7: busy goes to 1 in the cycle after a change is accepted and stays 1 until the bus is fast again. done is 1 for exactly the one cycle in which busSelFast has just risen, and busy is 0 in that cycle.
- R8: A request while idle, with busSelFast = 1 and a code equal to speedSel, gives done = 1 in the next cycle. busy stays 0, and busSelFast, pllEnable and speedSel do not change.
- R9: A request while busy is ignored: the sequence in progress finishes with its own code. reqError is 1 for the single cycle after that request.
- R10: A request with settle count 0 that is not a same-speed request is rejected. reqError is 1 for one cycle and all outputs except reqError stay unchanged.
- R11: The settle count is captured when a request is accepted. Later changes on settleCycles do not alter the timing of the change in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Speed change request strobe |
| reqSpeed | input | 2 | Requested speed code |
| settleCycles | input | 16 | Settle time N in reference cycles |
| busSelFast | output | 1 | 1 selects the PLL clock for the bus, 0 the reference clock |
| pllEnable | output | 1 | PLL enable |
| filterNarrow | output | 1 | 1 selects narrow loop bandwidth, 0 wide |
| speedSel | output | 2 | Speed code applied to the PLL divider |
| busy | output | 1 | A speed change is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| reqError | output | 1 | One-cycle pulse when a request is rejected |

## Verification
Two events can land on the same edge: the handover from wide to narrow bandwidth and the return of the bus to the fast clock. This happens when the settle count is below ten, because the tail of the wait then rounds down to zero cycles. The bench provokes it with settle counts of 1 and 5. It judges the result by the two distances from the pllEnable rise: the narrow rise and the bus rise must each land exactly N cycles out. A monitor that runs on every cycle also confirms that the bus is never fast without a narrow, enabled PLL.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DROP,
    ST_OFF,
    ST_LOAD,
    ST_ON,
    ST_WIDE,
    ST_NARROW
  } seqState_t;

  // One-cycle commands from the sequencer control to the datapath.
  typedef struct packed {
    logic latchReq;
    logic dropBus;
    logic pllOff;
    logic loadSpeed;
    logic pllOn;
    logic cntClear;
    logic cntRun;
    logic setNarrow;
    logic raiseBus;
    logic pulseDone;
    logic flagError;
  } seqStrobe_t;

endpackage

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       sameSpeed,
  input  logic       settleZero,
  input  logic       wideHit,
  input  logic       fullHit,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (sameSpeed) begin
            strobe.pulseDone = 1'b1;
          end else if (settleZero) begin
            strobe.flagError = 1'b1;
          end else begin
            strobe.latchReq = 1'b1;
            nextState       = ST_DROP;
          end
        end
      end
      ST_DROP: begin
        strobe.dropBus = 1'b1;
        nextState      = ST_OFF;
      end
      ST_OFF: begin
        strobe.pllOff = 1'b1;
        nextState     = ST_LOAD;
      end
      ST_LOAD: begin
        strobe.loadSpeed = 1'b1;
        nextState        = ST_ON;
      end
      ST_ON: begin
        strobe.pllOn    = 1'b1;
        strobe.cntClear = 1'b1;
        nextState       = ST_WIDE;
      end
      ST_WIDE: begin
        strobe.cntRun = 1'b1;
        if (wideHit) begin
          strobe.setNarrow = 1'b1;
          if (fullHit) begin
            strobe.raiseBus  = 1'b1;
            strobe.pulseDone = 1'b1;
            nextState        = ST_IDLE;
          end else begin
            nextState = ST_NARROW;
          end
        end
      end
      ST_NARROW: begin
        strobe.cntRun = 1'b1;
        if (fullHit) begin
          strobe.raiseBus  = 1'b1;
          strobe.pulseDone = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (reqValid && (state != ST_IDLE)) strobe.flagError = 1'b1;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pll_seq_dpath.sv
module pll_seq_dpath
  import pll_seq_pkg::*;
#(
  parameter int SPD_W    = 2,
  parameter int CNT_W    = 16,
  parameter int TAIL_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobe,
  input  logic [SPD_W-1:0] reqSpeed,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             busSelFast,
  output logic             pllEnable,
  output logic             filterNarrow,
  output logic [SPD_W-1:0] speedSel,
  output logic             done,
  output logic             reqError,
  output logic             sameSpeed,
  output logic             settleZero,
  output logic             wideHit,
  output logic             fullHit
);

  localparam int TAIL_SHIFT = $clog2(TAIL_DIV);
  localparam bit TAIL_POW2  = (TAIL_DIV > 0) && ((TAIL_DIV & (TAIL_DIV - 1)) == 0);

  logic [SPD_W-1:0] targetSpeed;
  logic [CNT_W-1:0] settleHeld;
  logic [CNT_W-1:0] tailCycles;
  logic [CNT_W-1:0] wideLimit;
  logic [CNT_W-1:0] cnt;

  // Tail fraction of the settle time: shift when the divisor allows it.
  generate
    if (TAIL_POW2) begin : g_tail_shift
      assign tailCycles = settleHeld >> TAIL_SHIFT;
    end else begin : g_tail_div
      assign tailCycles = settleHeld / CNT_W'(TAIL_DIV);
    end
  endgenerate

  assign wideLimit = settleHeld - tailCycles;
  assign wideHit   = (cnt == CNT_W'(wideLimit - CNT_W'(1)));
  assign fullHit   = (cnt == CNT_W'(settleHeld - CNT_W'(1)));

  assign sameSpeed  = busSelFast && (reqSpeed == speedSel);
  assign settleZero = (settleCycles == '0);

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      targetSpeed <= '0;
      settleHeld  <= '0;
    end else if (strobe.latchReq) begin
      targetSpeed <= reqSpeed;
      settleHeld  <= settleCycles;
    end
  end

  // Settle counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntRun)   cnt <= cnt + CNT_W'(1);
  end

  // Clock control outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busSelFast   <= 1'b0;
      pllEnable    <= 1'b0;
      filterNarrow <= 1'b0;
      speedSel     <= '0;
    end else begin
      if (strobe.dropBus)  busSelFast <= 1'b0;
      if (strobe.raiseBus) busSelFast <= 1'b1;
      if (strobe.pllOff) begin
        pllEnable    <= 1'b0;
        filterNarrow <= 1'b0;
      end
      if (strobe.pllOn)     pllEnable    <= 1'b1;
      if (strobe.setNarrow) filterNarrow <= 1'b1;
      if (strobe.loadSpeed) speedSel     <= targetSpeed;
    end
  end

  // Status pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      reqError <= 1'b0;
    end else begin
      done     <= strobe.pulseDone;
      reqError <= strobe.flagError;
    end
  end

endmodule

// File: rtl/pll_speed_sequencer.sv
module pll_speed_sequencer
  import pll_seq_pkg::*;
#(
  parameter int SPD_W    = 2,
  parameter int CNT_W    = 16,
  parameter int TAIL_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [SPD_W-1:0] reqSpeed,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             busSelFast,
  output logic             pllEnable,
  output logic             filterNarrow,
  output logic [SPD_W-1:0] speedSel,
  output logic             busy,
  output logic             done,
  output logic             reqError
);

  seqStrobe_t strobe;
  logic       sameSpeed;
  logic       settleZero;
  logic       wideHit;
  logic       fullHit;

  pll_seq_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .sameSpeed  (sameSpeed),
    .settleZero (settleZero),
    .wideHit    (wideHit),
    .fullHit    (fullHit),
    .strobe     (strobe),
    .busy       (busy)
  );

  pll_seq_dpath #(
    .SPD_W    (SPD_W),
    .CNT_W    (CNT_W),
    .TAIL_DIV (TAIL_DIV)
  ) dpath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .reqSpeed     (reqSpeed),
    .settleCycles (settleCycles),
    .busSelFast   (busSelFast),
    .pllEnable    (pllEnable),
    .filterNarrow (filterNarrow),
    .speedSel     (speedSel),
    .done         (done),
    .reqError     (reqError),
    .sameSpeed    (sameSpeed),
    .settleZero   (settleZero),
    .wideHit      (wideHit),
    .fullHit      (fullHit)
  );

endmodule

// File: rtl/pll_seq_checker.sv
module pll_seq_checker #(
  parameter int SPD_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             busSelFast,
  input logic             pllEnable,
  input logic             filterNarrow,
  input logic [SPD_W-1:0] speedSel,
  input logic             busy,
  input logic             done,
  input logic             reqError
);

  assert_drop_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pllEnable) |-> (!busSelFast && $past(!busSelFast)));

  assert_wide_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pllEnable |-> !filterNarrow);

  assert_speed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pllEnable || busSelFast) |=> $stable(speedSel));

  assert_fast_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busSelFast |-> (pllEnable && filterNarrow));

  assert_done_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busSelFast) |-> done);

  assert_idle_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reqValid) |=> reqError);

endmodule

bind pll_speed_sequencer pll_seq_checker #(.SPD_W(SPD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reqValid     (reqValid),
  .busSelFast   (busSelFast),
  .pllEnable    (pllEnable),
  .filterNarrow (filterNarrow),
  .speedSel     (speedSel),
  .busy         (busy),
  .done         (done),
  .reqError     (reqError)
);

// File: tb/pll_speed_sequencer_tb.sv
module pll_speed_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSpeed = '0;
  logic [15:0] settleCycles = '0;
  logic        busSelFast, pllEnable, filterNarrow, busy, done, reqError;
  logic [1:0]  speedSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pll_speed_sequencer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .reqSpeed     (reqSpeed),
    .settleCycles (settleCycles),
    .busSelFast   (busSelFast),
    .pllEnable    (pllEnable),
    .filterNarrow (filterNarrow),
    .speedSel     (speedSel),
    .busy         (busy),
    .done         (done),
    .reqError     (reqError)
  );

  // Event monitor: samples 1 ns after each rising edge.
  int cyc = 0;
  int tBusRise, tBusFall, tPllRise, tPllFall, tNarrowRise, tSpeedChg, tDone;
  int doneCount, errCount;
  int violR3 = 0, violR4 = 0, violR6 = 0;
  logic prevBus = 0, prevPll = 0, prevNarrow = 0;
  logic [1:0] prevSpd = '0;

  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      if (busSelFast && !prevBus) tBusRise = cyc;
      if (!busSelFast && prevBus) tBusFall = cyc;
      if (pllEnable && !prevPll) tPllRise = cyc;
      if (!pllEnable && prevPll) tPllFall = cyc;
      if (filterNarrow && !prevNarrow) tNarrowRise = cyc;
      if (speedSel != prevSpd) begin
        tSpeedChg = cyc;
        if (prevPll || prevBus) violR4++;
      end
      if (done) begin
        doneCount++;
        if (tDone < 0) tDone = cyc;
      end
      if (reqError) errCount++;
      if (filterNarrow && !pllEnable) violR3++;
      if (busSelFast && !(pllEnable && filterNarrow)) violR6++;
    end
    prevBus    = busSelFast;
    prevPll    = pllEnable;
    prevNarrow = filterNarrow;
    prevSpd    = speedSel;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMarks();
    tBusRise = -1; tBusFall = -1; tPllRise = -1; tPllFall = -1;
    tNarrowRise = -1; tSpeedChg = -1; tDone = -1;
    doneCount = 0; errCount = 0;
  endtask

  task automatic startReq(input logic [1:0] spd, input int n);
    @(negedge clk);
    reqValid     = 1'b1;
    reqSpeed     = spd;
    settleCycles = 16'(n);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit && doneCount == 0; i++) @(negedge clk);
  endtask

  task automatic checkReset();
    chk("R1", "busSelFast", busSelFast, 0);
    chk("R1", "pllEnable", pllEnable, 0);
    chk("R1", "filterNarrow", filterNarrow, 0);
    chk("R1", "speedSel", speedSel, 0);
    chk("R1", "busy/done/reqError", {busy, done, reqError}, 0);
  endtask

  task automatic runChange(input logic [1:0] spd, input int n);
    bit wasFast = busSelFast;
    int w = n - n / 10;
    clearMarks();
    startReq(spd, n);
    chk("R7", "busy after accept", busy, 1);
    waitDone(n + 60);
    chk("R7", "done seen once", doneCount, 1);
    chk("R7", "busy low in done cycle", busy, 0);
    chk("R5", "speedSel final", speedSel, spd);
    chk("R5", "narrow delay", tNarrowRise - tPllRise, w);
    chk("R6", "bus fast delay", tBusRise - tPllRise, n);
    chk("R7", "done with bus rise", tDone, tBusRise);
    chk("R6", "final pll/narrow/bus", {pllEnable, filterNarrow, busSelFast}, 3'b111);
    chk("R4", "speed write before pll on", int'(tSpeedChg >= 0 && tSpeedChg < tPllRise), 1);
    if (wasFast) begin
      chk("R2", "bus drop before pll off", int'(tBusFall >= 0 && tBusFall < tPllFall), 1);
      chk("R4", "speed write after pll off", int'(tSpeedChg > tPllFall), 1);
    end
    @(negedge clk);
    chk("R7", "done one cycle", done, 0);
  endtask

  task automatic sameSpeedReq();
    logic [1:0] s = speedSel;
    clearMarks();
    startReq(s, 40);
    chk("R8", "done next cycle", done, 1);
    chk("R8", "busy stays low", busy, 0);
    repeat (3) @(negedge clk);
    chk("R8", "no bus drop", tBusFall, -1);
    chk("R8", "no pll drop", tPllFall, -1);
    chk("R8", "speed kept", speedSel, s);
    chk("R8", "single done", doneCount, 1);
  endtask

  task automatic busyReq();
    clearMarks();
    startReq(2'd3, 50);
    repeat (10) @(negedge clk);
    reqValid     = 1'b1;
    reqSpeed     = 2'd0;
    settleCycles = 16'd5;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9", "error pulse", reqError, 1);
    @(negedge clk);
    chk("R9", "error one cycle", reqError, 0);
    waitDone(120);
    chk("R11", "latched settle timing", tBusRise - tPllRise, 50);
    chk("R9", "busy speed ignored", speedSel, 3);
    repeat (30) @(negedge clk);
    chk("R9", "no second sequence", busy, 0);
    chk("R9", "error count", errCount, 1);
    chk("R9", "speed still", speedSel, 3);
  endtask

  task automatic zeroSettle();
    logic [1:0] s = speedSel;
    clearMarks();
    startReq(s ^ 2'd1, 0);
    chk("R10", "error pulse", reqError, 1);
    chk("R10", "not busy", busy, 0);
    repeat (5) @(negedge clk);
    chk("R10", "speed unchanged", speedSel, s);
    chk("R10", "bus still fast", busSelFast, 1);
    chk("R10", "no bus drop", tBusFall, -1);
    chk("R10", "no done", doneCount, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run hung actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkReset();
    runChange(2'd1, 20);
    runChange(2'd2, 37);
    sameSpeedReq();
    busyReq();
    runChange(2'd0, 5);
    runChange(2'd1, 10);
    runChange(2'd2, 1);
    zeroSettle();
    chk("R3", "wide while off violations", violR3, 0);
    chk("R4", "speed change while live violations", violR4, 0);
    chk("R6", "fast bus unsettled violations", violR6, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule